// File: doc/BRIEF.md
# Memory Dependence Wakeup Scheduler

This block holds the loads and stores that are in flight in an out-of-order core and decides when each one may go to memory. Every operation carries a 16-bit sequence number, and smaller numbers are older. When an operation is inserted, the block sends its PC to an external dependence predictor. The predictor answers with the sequence number of the store that the operation is expected to depend on.

An operation issues only after two conditions hold: its operands are ready and its predicted store dependence is resolved. Operations with no live producing store count as dependence-resolved at once. An operation bound to a store waits until that store leaves through the issue port. Among the ready operations, the one with the smallest sequence number is offered for issue. Popping that operation wakes every operation bound to it.

Non-speculative operations wait for an explicit go signal. A squash removes everything younger than a given sequence number. Inserted stores, issues, squashes and ordering violations are all forwarded to the predictor. Four counters record insert activity.

Top module: `memdep_sched`

## Requirements
- R1: After reset, `issue_valid`, `full`, `ins_error` and all four counters are 0.
- R2: An inserted operation is dependence-free in two cases: `pred_hit_seq` is 0, or it equals no resident store. A dependence-free operation with `ins_regs_ready`=1 is offered at `issue_valid` from the cycle after the insert.
- R3: A dependence-free operation inserted with `ins_regs_ready`=0 is not offered until an `opnd_ready_valid` pulse carries its sequence number. It is offered from the cycle after that pulse.
- R4: An operation whose `pred_hit_seq` matches a resident store is not offered before that store is popped, even when its operands are ready.
- R5: Popping a store wakes the operations bound to it. Each bound operation whose operands are ready is offered from the next cycle. Each of the others still waits for its `opnd_ready_valid` pulse.
- R6: `issue_seq` is the smallest sequence number among the ready operations. Asserting `issue_pop` while `issue_valid`=1 removes that operation at the clock edge.
- R7: An accepted store insert raises `pred_store_valid` in the same cycle, with its PC and sequence number. A pop raises `pred_issued_valid` in the same cycle, with the popped PC, sequence number and store flag.
- R8: An operation inserted with `ins_nonspec`=1 is offered only after a `nonspec_go_valid` pulse carries its sequence number. Ready operands are not enough.
- R9: `squash_valid` removes every resident operation whose sequence number is larger than `squash_seq`. A removed operation is no longer woken by its store. The squash is forwarded on `pred_squash_*` in the same cycle. In a squash cycle, pops, inserts and readiness events are ignored.
- R10: `viol_valid` is forwarded in the same cycle on `pred_viol_valid`, with the load PC and the store PC unchanged.
- R11: Each accepted insert increments `cnt_loads` or `cnt_stores`. An accepted insert bound to a resident store also increments `cnt_conf_loads` or `cnt_conf_stores`.
- R12: `full` is 1 when all NE entries are occupied. An insert presented while `full`=1 has no effect.
- R13: An insert with `ins_is_load` and `ins_is_store` both 0 or both 1 raises `ins_error` in that cycle and is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request |
| ins_seq | input | SW | Sequence number of the inserted operation |
| ins_pc | input | PW | PC of the inserted operation |
| ins_is_load | input | 1 | Inserted operation is a load |
| ins_is_store | input | 1 | Inserted operation is a store |
| ins_regs_ready | input | 1 | Operands already available at insert |
| ins_nonspec | input | 1 | Operation must wait for an explicit go |
| full | output | 1 | No free entry; insert is ignored |
| ins_error | output | 1 | Insert has an illegal type |
| pred_lookup_pc | output | PW | PC sent to the predictor |
| pred_hit_seq | input | SW | Predicted producing store, 0 for none |
| pred_store_valid | output | 1 | Store accepted this cycle |
| pred_store_pc | output | PW | PC of that store |
| pred_store_seq | output | SW | Sequence number of that store |
| opnd_ready_valid | input | 1 | Operands became ready |
| opnd_ready_seq | input | SW | Operation whose operands became ready |
| nonspec_go_valid | input | 1 | Release a non-speculative operation |
| nonspec_go_seq | input | SW | Operation to release |
| issue_valid | output | 1 | A ready operation is offered |
| issue_seq | output | SW | Sequence number of the offered operation |
| issue_pc | output | PW | PC of the offered operation |
| issue_is_store | output | 1 | Offered operation is a store |
| issue_pop | input | 1 | Take the offered operation |
| pred_issued_valid | output | 1 | Operation popped this cycle |
| pred_issued_pc | output | PW | PC of the popped operation |
| pred_issued_seq | output | SW | Sequence number of the popped operation |
| pred_issued_is_store | output | 1 | Popped operation is a store |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SW | Operations younger than this are removed |
| pred_squash_valid | output | 1 | Forwarded squash |
| pred_squash_seq | output | SW | Forwarded squash boundary |
| viol_valid | input | 1 | Ordering violation detected |
| viol_load_pc | input | PW | PC of the violating load |
| viol_store_pc | input | PW | PC of the store it bypassed |
| pred_viol_valid | output | 1 | Forwarded violation |
| pred_viol_load_pc | output | PW | Forwarded load PC |
| pred_viol_store_pc | output | PW | Forwarded store PC |
| cnt_loads | output | CW | Accepted load inserts |
| cnt_stores | output | CW | Accepted store inserts |
| cnt_conf_loads | output | CW | Accepted loads bound to a store |
| cnt_conf_stores | output | CW | Accepted stores bound to a store |

## Verification
The wakeup path is exercised with three kinds of predictor answer: zero, a number that matches no resident store, and the number of a resident store. This separates real binding from the two no-dependence cases. Bound operations are inserted with operands both ready and not ready, so a store pop must move the first kind straight to issue and leave the second waiting. Several operations are ready at once so that the issue order shows oldest-first selection rather than order of arrival. The remaining cases cover squash, non-speculative release and full: an operation younger than the squash boundary is bound to a store, a non-speculative operation has ready operands, and a ready operation is inserted while the block is full. Each of these would reach issue if the block mishandled it.

// File: rtl/memdep_sched.sv
module memdep_sched #(
  parameter int NE = 16,
  parameter int SW = 16,
  parameter int PW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_valid,
  input  logic [SW-1:0] ins_seq,
  input  logic [PW-1:0] ins_pc,
  input  logic          ins_is_load,
  input  logic          ins_is_store,
  input  logic          ins_regs_ready,
  input  logic          ins_nonspec,
  output logic          full,
  output logic          ins_error,
  output logic [PW-1:0] pred_lookup_pc,
  input  logic [SW-1:0] pred_hit_seq,
  output logic          pred_store_valid,
  output logic [PW-1:0] pred_store_pc,
  output logic [SW-1:0] pred_store_seq,
  input  logic          opnd_ready_valid,
  input  logic [SW-1:0] opnd_ready_seq,
  input  logic          nonspec_go_valid,
  input  logic [SW-1:0] nonspec_go_seq,
  output logic          issue_valid,
  output logic [SW-1:0] issue_seq,
  output logic [PW-1:0] issue_pc,
  output logic          issue_is_store,
  input  logic          issue_pop,
  output logic          pred_issued_valid,
  output logic [PW-1:0] pred_issued_pc,
  output logic [SW-1:0] pred_issued_seq,
  output logic          pred_issued_is_store,
  input  logic          squash_valid,
  input  logic [SW-1:0] squash_seq,
  output logic          pred_squash_valid,
  output logic [SW-1:0] pred_squash_seq,
  input  logic          viol_valid,
  input  logic [PW-1:0] viol_load_pc,
  input  logic [PW-1:0] viol_store_pc,
  output logic          pred_viol_valid,
  output logic [PW-1:0] pred_viol_load_pc,
  output logic [PW-1:0] pred_viol_store_pc,
  output logic [CW-1:0] cnt_loads,
  output logic [CW-1:0] cnt_stores,
  output logic [CW-1:0] cnt_conf_loads,
  output logic [CW-1:0] cnt_conf_stores
);
  localparam int IW = (NE > 1) ? $clog2(NE) : 1;

  // per-entry state: valid, store, operands ready, dependence resolved,
  // non-speculative, in ready pool, bound to a store
  logic [NE-1:0] v_q, st_q, rr_q, mr_q, ns_q, rdy_q, hd_q;
  logic [NE-1:0] v_n, st_n, rr_n, mr_n, ns_n, rdy_n, hd_n;
  logic [SW-1:0] seq_q [NE];
  logic [SW-1:0] seq_n [NE];
  logic [PW-1:0] pc_q  [NE];
  logic [PW-1:0] pc_n  [NE];
  logic [IW-1:0] dep_q [NE];
  logic [IW-1:0] dep_n [NE];

  logic          legal, do_ins, do_pop, live_dep;
  logic          sel_v, hit;
  logic [IW-1:0] sel, hidx, fidx;

  assign full      = &v_q;
  assign legal     = ins_is_load ^ ins_is_store;
  assign ins_error = ins_valid & ~legal;
  assign do_ins    = ins_valid & legal & ~full & ~squash_valid;
  assign do_pop    = issue_pop & sel_v & ~squash_valid;

  always_comb begin
    sel_v = 1'b0;
    sel   = '0;
    for (int i = 0; i < NE; i++)
      if (v_q[i] && rdy_q[i] && (!sel_v || seq_q[i] < seq_q[sel])) begin
        sel_v = 1'b1;
        sel   = IW'(i);
      end
  end

  always_comb begin
    hit  = 1'b0;
    hidx = '0;
    for (int j = 0; j < NE; j++)
      if (v_q[j] && st_q[j] && pred_hit_seq != '0 && seq_q[j] == pred_hit_seq) begin
        hit  = 1'b1;
        hidx = IW'(j);
      end
  end

  // a store popped in this cycle no longer holds a dependent list
  assign live_dep = hit & ~(do_pop & hidx == sel);

  always_comb begin
    fidx = '0;
    for (int k = NE - 1; k >= 0; k--)
      if (!v_q[k]) fidx = IW'(k);
  end

  assign issue_valid    = sel_v;
  assign issue_seq      = seq_q[sel];
  assign issue_pc       = pc_q[sel];
  assign issue_is_store = st_q[sel];

  assign pred_lookup_pc       = ins_pc;
  assign pred_store_valid     = do_ins & ins_is_store;
  assign pred_store_pc        = ins_pc;
  assign pred_store_seq       = ins_seq;
  assign pred_issued_valid    = do_pop;
  assign pred_issued_pc       = issue_pc;
  assign pred_issued_seq      = issue_seq;
  assign pred_issued_is_store = issue_is_store;
  assign pred_squash_valid    = squash_valid;
  assign pred_squash_seq      = squash_seq;
  assign pred_viol_valid      = viol_valid;
  assign pred_viol_load_pc    = viol_load_pc;
  assign pred_viol_store_pc   = viol_store_pc;

  always_comb begin
    v_n = v_q;  st_n = st_q;  rr_n = rr_q;  mr_n = mr_q;
    ns_n = ns_q; rdy_n = rdy_q; hd_n = hd_q;
    seq_n = seq_q; pc_n = pc_q; dep_n = dep_q;
    if (squash_valid) begin
      for (int i = 0; i < NE; i++)
        if (seq_q[i] > squash_seq) begin
          v_n[i] = 1'b0; rdy_n[i] = 1'b0; hd_n[i] = 1'b0;
        end
    end else begin
      if (do_pop) begin
        v_n[sel] = 1'b0;
        rdy_n[sel] = 1'b0;
        if (st_q[sel])
          for (int i = 0; i < NE; i++)
            if (v_q[i] && hd_q[i] && dep_q[i] == sel) begin
              hd_n[i] = 1'b0;
              mr_n[i] = 1'b1;
            end
      end
      if (opnd_ready_valid)
        for (int i = 0; i < NE; i++)
          if (v_q[i] && !rdy_q[i] && seq_q[i] == opnd_ready_seq) rr_n[i] = 1'b1;
      if (nonspec_go_valid)
        for (int i = 0; i < NE; i++)
          if (v_q[i] && ns_q[i] && seq_q[i] == nonspec_go_seq) rdy_n[i] = 1'b1;
      if (do_ins) begin
        v_n[fidx]   = 1'b1;
        st_n[fidx]  = ins_is_store;
        rr_n[fidx]  = ins_regs_ready;
        mr_n[fidx]  = ~live_dep;
        ns_n[fidx]  = ins_nonspec;
        hd_n[fidx]  = live_dep;
        rdy_n[fidx] = 1'b0;
        seq_n[fidx] = ins_seq;
        pc_n[fidx]  = ins_pc;
        dep_n[fidx] = hidx;
      end
      for (int i = 0; i < NE; i++)
        if (v_n[i] && !ns_n[i] && rr_n[i] && mr_n[i]) rdy_n[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= '0; st_q <= '0; rr_q <= '0; mr_q <= '0;
      ns_q <= '0; rdy_q <= '0; hd_q <= '0;
    end else begin
      v_q <= v_n; st_q <= st_n; rr_q <= rr_n; mr_q <= mr_n;
      ns_q <= ns_n; rdy_q <= rdy_n; hd_q <= hd_n;
    end
  end

  always_ff @(posedge clk) begin
    seq_q <= seq_n;
    pc_q  <= pc_n;
    dep_q <= dep_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_loads <= '0; cnt_stores <= '0;
      cnt_conf_loads <= '0; cnt_conf_stores <= '0;
    end else if (do_ins) begin
      if (ins_is_store) begin
        cnt_stores <= cnt_stores + 1'b1;
        if (live_dep) cnt_conf_stores <= cnt_conf_stores + 1'b1;
      end else begin
        cnt_loads <= cnt_loads + 1'b1;
        if (live_dep) cnt_conf_loads <= cnt_conf_loads + 1'b1;
      end
    end
  end

  // checker state
  logic [SW-1:0] sq_q;
  logic [IW-1:0] last_sel;
  logic          young_left, orphan;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sq_q <= '0;
      last_sel <= '0;
    end else begin
      if (squash_valid) sq_q <= squash_seq;
      last_sel <= sel;
    end
  end

  always_comb begin
    young_left = 1'b0;
    orphan = 1'b0;
    for (int i = 0; i < NE; i++) begin
      if (v_q[i] && seq_q[i] > sq_q) young_left = 1'b1;
      if (v_q[i] && hd_q[i] && dep_q[i] == last_sel) orphan = 1'b1;
    end
  end

  a_r9_squash_clears: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |=> !young_left);

  a_r5_wake_unbinds: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && issue_is_store) |=> !orphan);

  a_r6_ready_persists: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !issue_pop && !squash_valid) |=> issue_valid);

  a_r12_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !issue_pop && !squash_valid) |=> full);

  a_r13_error_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_error && !issue_pop && !squash_valid) |=> $stable(v_q));
endmodule

// File: tb/memdep_sched_tb.sv
module memdep_sched_tb_top;
  localparam int CLK_P = 10;
  localparam int NE = 16, SW = 16, PW = 32, CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_valid = 0, ins_is_load = 0, ins_is_store = 0, ins_regs_ready = 0, ins_nonspec = 0;
  logic [SW-1:0] ins_seq = '0, pred_hit_seq = '0, opnd_ready_seq = '0, nonspec_go_seq = '0, squash_seq = '0;
  logic [PW-1:0] ins_pc = '0, viol_load_pc = '0, viol_store_pc = '0;
  logic opnd_ready_valid = 0, nonspec_go_valid = 0, issue_pop = 0, squash_valid = 0, viol_valid = 0;
  logic full, ins_error, pred_store_valid, issue_valid, issue_is_store;
  logic pred_issued_valid, pred_issued_is_store, pred_squash_valid, pred_viol_valid;
  logic [PW-1:0] pred_lookup_pc, pred_store_pc, issue_pc, pred_issued_pc, pred_viol_load_pc, pred_viol_store_pc;
  logic [SW-1:0] pred_store_seq, issue_seq, pred_issued_seq, pred_squash_seq;
  logic [CW-1:0] cnt_loads, cnt_stores, cnt_conf_loads, cnt_conf_stores;

  always #(CLK_P/2) clk = ~clk;

  memdep_sched #(.NE(NE), .SW(SW), .PW(PW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_seq(ins_seq), .ins_pc(ins_pc),
    .ins_is_load(ins_is_load), .ins_is_store(ins_is_store),
    .ins_regs_ready(ins_regs_ready), .ins_nonspec(ins_nonspec),
    .full(full), .ins_error(ins_error),
    .pred_lookup_pc(pred_lookup_pc), .pred_hit_seq(pred_hit_seq),
    .pred_store_valid(pred_store_valid), .pred_store_pc(pred_store_pc), .pred_store_seq(pred_store_seq),
    .opnd_ready_valid(opnd_ready_valid), .opnd_ready_seq(opnd_ready_seq),
    .nonspec_go_valid(nonspec_go_valid), .nonspec_go_seq(nonspec_go_seq),
    .issue_valid(issue_valid), .issue_seq(issue_seq), .issue_pc(issue_pc),
    .issue_is_store(issue_is_store), .issue_pop(issue_pop),
    .pred_issued_valid(pred_issued_valid), .pred_issued_pc(pred_issued_pc),
    .pred_issued_seq(pred_issued_seq), .pred_issued_is_store(pred_issued_is_store),
    .squash_valid(squash_valid), .squash_seq(squash_seq),
    .pred_squash_valid(pred_squash_valid), .pred_squash_seq(pred_squash_seq),
    .viol_valid(viol_valid), .viol_load_pc(viol_load_pc), .viol_store_pc(viol_store_pc),
    .pred_viol_valid(pred_viol_valid), .pred_viol_load_pc(pred_viol_load_pc),
    .pred_viol_store_pc(pred_viol_store_pc),
    .cnt_loads(cnt_loads), .cnt_stores(cnt_stores),
    .cnt_conf_loads(cnt_conf_loads), .cnt_conf_stores(cnt_conf_stores)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_in();
    ins_valid = 0; ins_is_load = 0; ins_is_store = 0; ins_regs_ready = 0; ins_nonspec = 0;
    opnd_ready_valid = 0; nonspec_go_valid = 0; issue_pop = 0; squash_valid = 0; viol_valid = 0;
    pred_hit_seq = '0;
  endtask

  task automatic drive_ins(input logic st, input logic [SW-1:0] s, input logic rr,
                           input logic [SW-1:0] pred, input logic nsp);
    ins_valid = 1; ins_is_store = st; ins_is_load = ~st; ins_seq = s;
    ins_pc = PW'(s) * 4; ins_regs_ready = rr; pred_hit_seq = pred; ins_nonspec = nsp;
  endtask

  task automatic tick();
    @(posedge clk); #1; clear_in();
  endtask

  // op: 0 load, 1 store, 2 operands ready, 3 pop, 4 squash, 5 non-spec load, 6 non-spec go
  // fields: op[52:50] seq[49:34] regs[33] pred[32:17] exp_valid[16] exp_seq[15:0]
  localparam int NSTEP = 22;
  localparam logic [52:0] TBL [NSTEP] = '{
    {3'd1, 16'd10, 1'b1, 16'd0,  1'b1, 16'd10},
    {3'd0, 16'd12, 1'b1, 16'd10, 1'b1, 16'd10},
    {3'd0, 16'd13, 1'b0, 16'd10, 1'b1, 16'd10},
    {3'd0, 16'd14, 1'b1, 16'd99, 1'b1, 16'd10},
    {3'd3, 16'd0,  1'b0, 16'd0,  1'b1, 16'd12},
    {3'd3, 16'd0,  1'b0, 16'd0,  1'b1, 16'd14},
    {3'd2, 16'd13, 1'b0, 16'd0,  1'b1, 16'd13},
    {3'd3, 16'd0,  1'b0, 16'd0,  1'b1, 16'd14},
    {3'd3, 16'd0,  1'b0, 16'd0,  1'b0, 16'd0},
    {3'd0, 16'd20, 1'b0, 16'd0,  1'b0, 16'd0},
    {3'd2, 16'd20, 1'b0, 16'd0,  1'b1, 16'd20},
    {3'd5, 16'd21, 1'b1, 16'd0,  1'b1, 16'd20},
    {3'd3, 16'd0,  1'b0, 16'd0,  1'b0, 16'd0},
    {3'd6, 16'd21, 1'b0, 16'd0,  1'b1, 16'd21},
    {3'd3, 16'd0,  1'b0, 16'd0,  1'b0, 16'd0},
    {3'd1, 16'd30, 1'b0, 16'd0,  1'b0, 16'd0},
    {3'd0, 16'd31, 1'b1, 16'd30, 1'b0, 16'd0},
    {3'd0, 16'd32, 1'b1, 16'd0,  1'b1, 16'd32},
    {3'd1, 16'd33, 1'b1, 16'd30, 1'b1, 16'd32},
    {3'd4, 16'd30, 1'b0, 16'd0,  1'b0, 16'd0},
    {3'd2, 16'd30, 1'b0, 16'd0,  1'b1, 16'd30},
    {3'd3, 16'd0,  1'b0, 16'd0,  1'b0, 16'd0}
  };

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    check("R1 issue_valid", issue_valid, 0);
    check("R1 full", full, 0);
    check("R1 ins_error", ins_error, 0);
    check("R1 counters", cnt_loads + cnt_stores + cnt_conf_loads + cnt_conf_stores, 0);

    // R2 R3 R4 R5 R6 R8 R9 wakeup table
    for (int k = 0; k < NSTEP; k++) begin
      logic [52:0] e;
      e = TBL[k];
      case (e[52:50])
        3'd0: drive_ins(1'b0, e[49:34], e[33], e[32:17], 1'b0);
        3'd1: drive_ins(1'b1, e[49:34], e[33], e[32:17], 1'b0);
        3'd2: begin opnd_ready_valid = 1; opnd_ready_seq = e[49:34]; end
        3'd3: issue_pop = 1;
        3'd4: begin squash_valid = 1; squash_seq = e[49:34]; end
        3'd5: drive_ins(1'b0, e[49:34], e[33], e[32:17], 1'b1);
        default: begin nonspec_go_valid = 1; nonspec_go_seq = e[49:34]; end
      endcase
      tick();
      check($sformatf("R2/R3/R4/R5/R6/R8/R9 step %0d issue_valid", k), issue_valid, e[16]);
      if (e[16]) check($sformatf("R6 step %0d issue_seq", k), issue_seq, e[15:0]);
    end

    check("R11 cnt_loads", cnt_loads, 7);
    check("R11 cnt_stores", cnt_stores, 3);
    check("R11 cnt_conf_loads", cnt_conf_loads, 3);
    check("R11 cnt_conf_stores", cnt_conf_stores, 1);

    // R7 store report and issue report
    drive_ins(1'b1, 16'd50, 1'b1, 16'd0, 1'b0);
    #1;
    check("R7 pred_store_valid", pred_store_valid, 1);
    check("R7 pred_store_seq", pred_store_seq, 50);
    check("R7 pred_store_pc", pred_store_pc, 200);
    tick();
    check("R2 store ready", issue_seq, 50);
    issue_pop = 1;
    #1;
    check("R7 pred_issued_valid", pred_issued_valid, 1);
    check("R7 pred_issued_seq", pred_issued_seq, 50);
    check("R7 pred_issued_is_store", pred_issued_is_store, 1);
    check("R7 pred_issued_pc", pred_issued_pc, 200);
    tick();
    check("R6 pop empties", issue_valid, 0);

    // R10 violation forwarding
    viol_valid = 1; viol_load_pc = 32'h1234; viol_store_pc = 32'h5678;
    #1;
    check("R10 pred_viol_valid", pred_viol_valid, 1);
    check("R10 load pc", pred_viol_load_pc, 32'h1234);
    check("R10 store pc", pred_viol_store_pc, 32'h5678);
    tick();

    // R9 squash beats insert
    drive_ins(1'b0, 16'd60, 1'b1, 16'd0, 1'b0);
    squash_valid = 1; squash_seq = 16'd55;
    #1;
    check("R9 pred_squash_valid", pred_squash_valid, 1);
    check("R9 pred_squash_seq", pred_squash_seq, 55);
    tick();
    check("R9 insert dropped in squash cycle", issue_valid, 0);

    // R13 illegal type
    drive_ins(1'b0, 16'd70, 1'b1, 16'd0, 1'b0);
    ins_is_load = 0;
    #1;
    check("R13 ins_error", ins_error, 1);
    tick();
    check("R13 not inserted", issue_valid, 0);

    // R12 fill to capacity
    for (int k = 0; k < NE; k++) begin
      drive_ins(1'b0, 16'(100 + k), 1'b0, 16'd0, 1'b0);
      tick();
    end
    check("R12 full", full, 1);
    drive_ins(1'b0, 16'd200, 1'b1, 16'd0, 1'b0);
    tick();
    check("R12 insert ignored when full", issue_valid, 0);
    check("R12 still full", full, 1);
    squash_valid = 1; squash_seq = 16'd99;
    tick();
    check("R9 squash empties", full, 0);
    check("R9 squash leaves nothing ready", issue_valid, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule